// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It walks a radix-512 page table that lives in memory, one level per memory read. A caller presents a virtual address, the physical base of the top-level table and the kind of access: write or read, user or supervisor, instruction fetch or data. The walker then reads one 64-bit entry per level through a request/response memory port, starting at the top table.

A walk ends in one of three ways:
- at a 4 KB page on the lowest level;
- early, at a 1 GB page on level 3 or a 2 MB page on level 2, when the entry's page-size flag is set;
- at the first entry that is not present.

The write and user rights of all entries read on the way are combined, and so are their no-execute marks. The access is checked against these combined rights at the leaf. A single-cycle done pulse then returns the physical address, or a fault code, together with the level at which the walk stopped.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req_valid` and `done_valid` are 0.
- R2: Levels are read from 4 down to 1, each with a one-cycle `mem_req_valid` pulse. The entry address is the table base (the low 12 bits forced to zero) plus the level's index times 8. The indices are virtual address bits 47:39, 38:30, 29:21 and 20:12 for levels 4, 3, 2 and 1. Level 4 uses `req_root` as its base. Each deeper level uses bits 51:12 of the entry read before it. A walk that stops at level L makes exactly 5-L reads.
- R3: An entry with bit 0 clear ends the walk with `done_fault` = 1 (not present) and `done_level` = the level of that entry. This holds even when bit 7 of that entry is set.
- R4: A level-1 entry gives the address {entry[51:12], va[11:0]} with `done_level` = 1. Entry bits 62:52 have no effect.
- R5: A present level-2 entry with bit 7 set ends the walk with the address {entry[51:21], va[20:0]} and `done_level` = 2.
- R6: A present level-3 entry with bit 7 set ends the walk with the address {entry[51:30], va[29:0]} and `done_level` = 3. Entry bits 29:12 have no effect.
- R7: Bit 7 has no effect at level 4 or level 1. A successful walk never stops at level 4.
- R8: A write faults with `done_fault` = 2 (protection) at the leaf level unless bit 1 is set in every entry read.
- R9: A user access faults with `done_fault` = 2 unless bit 2 is set in every entry read.
- R10: A fetch faults with `done_fault` = 2 when bit 63 is set in any entry read. Bit 63 does not affect a non-fetch access.
- R11: A request is accepted only while `req_ready` is 1. `req_ready` drops in the cycle after acceptance and returns in the cycle after the single-cycle `done_valid` pulse. `req_valid` has no effect while the walker is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 48 | Virtual address |
| req_root | input | 52 | Top-level table base (low 12 bits ignored) |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Entry read request (one cycle) |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done_valid | output | 1 | Walk finished (one cycle) |
| done_paddr | output | 52 | Physical address (zero on a fault) |
| done_fault | output | 2 | 0 none, 1 not present, 2 protection |
| done_level | output | 3 | Level where the walk stopped (1..4) |

## Verification
A wrong level counter or base register shows up at once on `mem_req_addr` of the next read. It also changes the number of reads a walk makes. For this reason every table walk checks each read address and the read count. Corrupted accumulated rights stay hidden until the leaf. They then show up as a wrong `done_fault` in the done pulse of that same walk. A wrong leaf decision shows up as a wrong `done_level`, or as an extra or missing read. A stuck state machine shows up as `req_ready` failing to return in the cycle after `done_valid`, which is checked after every walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 52;
    localparam int ENT_W  = 64;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 9;
    localparam int LEVELS = 4;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int ESH    = $clog2(ENT_W / 8);

    localparam int BIT_P  = 0;
    localparam int BIT_W  = 1;
    localparam int BIT_U  = 2;
    localparam int BIT_PS = 7;
    localparam int BIT_NX = 63;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_PROT = 2'd2} flt_e;

    typedef struct packed {
        st_e              st;
        logic [VA_W-1:0]  va;
        logic [PA_W-1:0]  base;
        logic [LVL_W-1:0] lvl;
        logic             wr;
        logic             usr;
        logic             fch;
        logic             ok_w;
        logic             ok_u;
        logic             nx;
        logic [PA_W-1:0]  pa;
        flt_e             flt;
    } walk_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [PA_W-1:0]  base,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  addr
);
    logic [IDX_W-1:0] idx [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[OFF_W + g*IDX_W +: IDX_W];
    end

    assign addr = {base[PA_W-1:OFF_W], {OFF_W{1'b0}}}
                + PA_W'({idx[lvl], {ESH{1'b0}}});
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    input  logic             wr,
    input  logic             usr,
    input  logic             fch,
    input  logic             ok_w,
    input  logic             ok_u,
    input  logic             nx,
    output logic             present,
    output logic             leaf,
    output logic             nxt_w,
    output logic             nxt_u,
    output logic             nxt_nx,
    output logic [PA_W-1:0]  pa,
    output logic [PA_W-1:0]  next_base,
    output flt_e             flt
);
    logic [LEVELS-1:0] stop;
    logic [PA_W-1:0]   pg [LEVELS];
    logic              denied;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int SH = OFF_W + g*IDX_W;
        if (g == 0) begin : g_base
            assign stop[g] = 1'b1;
            assign pg[g]   = {entry[PA_W-1:SH], va[SH-1:0]};
        end else if (g == LEVELS-1) begin : g_top
            assign stop[g] = 1'b0;
            assign pg[g]   = '0;
        end else begin : g_large
            assign stop[g] = entry[BIT_PS];
            assign pg[g]   = {entry[PA_W-1:SH], va[SH-1:0]};
        end
    end

    assign present   = entry[BIT_P];
    assign leaf      = stop[lvl];
    assign nxt_w     = ok_w & entry[BIT_W];
    assign nxt_u     = ok_u & entry[BIT_U];
    assign nxt_nx    = nx | entry[BIT_NX];
    assign pa        = pg[lvl];
    assign next_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    assign denied    = (wr & ~nxt_w) | (usr & ~nxt_u) | (fch & nxt_nx);

    always_comb begin
        if (!present)             flt = FLT_ABSENT;
        else if (leaf && denied)  flt = FLT_PROT;
        else                      flt = FLT_NONE;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             req_fetch,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             done_valid,
    output logic [PA_W-1:0]  done_paddr,
    output logic [1:0]       done_fault,
    output logic [2:0]       done_level
);
    walk_t s_q, s_d;

    logic            present_c, leaf_c, nw_c, nu_c, nnx_c;
    logic [PA_W-1:0] pa_c, nbase_c, addr_c;
    flt_e            flt_c;

    ptw_entry_addr u_addr (
        .va   (s_q.va),
        .base (s_q.base),
        .lvl  (s_q.lvl),
        .addr (addr_c)
    );

    ptw_leaf u_leaf (
        .entry     (mem_rsp_data),
        .va        (s_q.va),
        .lvl       (s_q.lvl),
        .wr        (s_q.wr),
        .usr       (s_q.usr),
        .fch       (s_q.fch),
        .ok_w      (s_q.ok_w),
        .ok_u      (s_q.ok_u),
        .nx        (s_q.nx),
        .present   (present_c),
        .leaf      (leaf_c),
        .nxt_w     (nw_c),
        .nxt_u     (nu_c),
        .nxt_nx    (nnx_c),
        .pa        (pa_c),
        .next_base (nbase_c),
        .flt       (flt_c)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = ST_ISSUE;
                    s_d.va   = req_vaddr;
                    s_d.base = {req_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                    s_d.lvl  = LVL_W'(LEVELS-1);
                    s_d.wr   = req_write;
                    s_d.usr  = req_user;
                    s_d.fch  = req_fetch;
                    s_d.ok_w = 1'b1;
                    s_d.ok_u = 1'b1;
                    s_d.nx   = 1'b0;
                    s_d.pa   = '0;
                    s_d.flt  = FLT_NONE;
                end
            end
            ST_ISSUE: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.ok_w = nw_c;
                    s_d.ok_u = nu_c;
                    s_d.nx   = nnx_c;
                    if (!present_c || leaf_c) begin
                        s_d.st  = ST_DONE;
                        s_d.flt = flt_c;
                        s_d.pa  = (flt_c == FLT_NONE) ? pa_c : '0;
                    end else begin
                        s_d.st   = ST_ISSUE;
                        s_d.base = nbase_c;
                        s_d.lvl  = s_q.lvl - LVL_W'(1);
                    end
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign mem_req_valid = (s_q.st == ST_ISSUE);
    assign mem_req_addr  = addr_c;
    assign done_valid    = (s_q.st == ST_DONE);
    assign done_paddr    = s_q.pa;
    assign done_fault    = s_q.flt;
    assign done_level    = 3'({1'b0, s_q.lvl}) + 3'd1;

    // R11: done is a single-cycle pulse, after which the walker is idle again
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready);
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R2: the first read targets the top table at the level-4 index
    a_r2_top_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && mem_req_addr ==
            ({$past(req_root[PA_W-1:OFF_W]), {OFF_W{1'b0}}}
             + PA_W'({$past(req_vaddr[VA_W-1 -: IDX_W]), {ESH{1'b0}}}))));
    // R2: each read request is a one-cycle pulse
    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R7: a successful walk never ends at the top level
    a_r7_no_top_leaf: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 2'd0) |-> (done_level != 3'd4));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [47:0] va;
        logic [2:0]  acc;
        logic [63:0] e4;
        logic [63:0] e3;
        logic [63:0] e2;
        logic [63:0] e1;
        logic [51:0] pa;
        logic [1:0]  flt;
        logic [2:0]  lvl;
    } vec_t;

    localparam logic [47:0] VA0 = 48'h0080_8060_4567;
    localparam logic [47:0] VAM = 48'hFFFF_FFFF_FFFF;
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{VA0, 3'b000, 64'h2007, 64'h3007, 64'h4007, 64'hABCDE007, 52'hABCDE567, 2'd0, 3'd1},
        '{VA0, 3'b000, 64'h2007, 64'h3007, 64'h1_2340_0087, 64'h0, 52'h1_2340_4567, 2'd0, 3'd2},
        '{VA0, 3'b000, 64'h2007, 64'h5_4012_3087, 64'h0, 64'h0, 52'h5_4060_4567, 2'd0, 3'd3},
        '{VA0, 3'b000, 64'h2087, 64'h3007, 64'h4007, 64'hABCDE007, 52'hABCDE567, 2'd0, 3'd1},
        '{VA0, 3'b000, 64'h2007, 64'h3007, 64'h4007, 64'hABCDE087, 52'hABCDE567, 2'd0, 3'd1},
        '{VA0, 3'b000, 64'h2007, 64'h3006, 64'h4007, 64'hABCDE007, 52'h0, 2'd1, 3'd3},
        '{VA0, 3'b000, 64'h2007, 64'h3007, 64'h4007, 64'hABCDE006, 52'h0, 2'd1, 3'd1},
        '{VA0, 3'b100, 64'h2005, 64'h3007, 64'h4007, 64'hABCDE007, 52'h0, 2'd2, 3'd1},
        '{VA0, 3'b100, 64'h2007, 64'h3007, 64'h4007, 64'hABCDE007, 52'hABCDE567, 2'd0, 3'd1},
        '{VA0, 3'b010, 64'h2007, 64'h3007, 64'h4003, 64'hABCDE007, 52'h0, 2'd2, 3'd1},
        '{VA0, 3'b001, 64'h2007, 64'h8000_0000_0000_3007, 64'h4007, 64'hABCDE007, 52'h0, 2'd2, 3'd1},
        '{VA0, 3'b000, 64'h2007, 64'h8000_0000_0000_3007, 64'h4007, 64'hABCDE007, 52'hABCDE567, 2'd0, 3'd1},
        '{VA0, 3'b100, 64'h2005, 64'h3007, 64'h1_2340_0087, 64'h0, 52'h0, 2'd2, 3'd2},
        '{VA0, 3'b000, 64'h2007, 64'h3007, 64'h80, 64'h0, 52'h0, 2'd1, 3'd2},
        '{VAM, 3'b000, 64'h2007, 64'h3007, 64'h4007, 64'h7FFF_FFFF_FFFF_F007, 52'hF_FFFF_FFFF_FFFF, 2'd0, 3'd1},
        '{VA0, 3'b010, 64'h2007, 64'h3007, 64'h4007, 64'hABCDE007, 52'hABCDE567, 2'd0, 3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [51:0] req_root = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [51:0] done_paddr;
    logic [1:0]  done_fault;
    logic [2:0]  done_level;

    int checks = 0;
    int fails = 0;
    int nrd = 0;
    logic [51:0] rlog [8];
    logic [51:0] m_a [4];
    logic [63:0] m_d [4];
    logic [51:0] r_pa;
    logic [1:0]  r_flt;
    logic [2:0]  r_lvl;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_paddr(done_paddr),
        .done_fault(done_fault), .done_level(done_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_mem(input vec_t v);
        m_a[0] = 52'h1000 + {40'b0, v.va[47:39], 3'b0}; m_d[0] = v.e4;
        m_a[1] = 52'h2000 + {40'b0, v.va[38:30], 3'b0}; m_d[1] = v.e3;
        m_a[2] = 52'h3000 + {40'b0, v.va[29:21], 3'b0}; m_d[2] = v.e2;
        m_a[3] = 52'h4000 + {40'b0, v.va[20:12], 3'b0}; m_d[3] = v.e1;
    endtask

    // memory responder: answers each read one cycle after the request
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [63:0] d;
                d = 64'h0;
                if (nrd < 8) rlog[nrd] = mem_req_addr;
                nrd++;
                for (int k = 0; k < 4; k++)
                    if (m_a[k] == mem_req_addr) d = m_d[k];
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d;
            end
        end
    end

    task automatic run_walk(input logic [47:0] va, input logic [51:0] root,
                            input logic [2:0] acc, input bit hold_busy);
        int t;
        @(negedge clk);
        nrd = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        {req_write, req_user, req_fetch} = acc;
        @(negedge clk);
        chk("R11 ready low after accept", {63'b0, req_ready}, 64'd0);
        if (hold_busy) begin
            req_vaddr = VAM;
            req_write = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        t = 0;
        while (!done_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk("R11 walk completes", {63'b0, done_valid}, 64'd1);
        r_pa  = done_paddr;
        r_flt = done_fault;
        r_lvl = done_level;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 done is one cycle", {63'b0, done_valid}, 64'd0);
        chk("R11 ready returns", {63'b0, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready at reset", {63'b0, req_ready}, 64'd1);
        chk("R1 no read at reset", {63'b0, mem_req_valid}, 64'd0);
        chk("R1 no done at reset", {63'b0, done_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {63'b0, req_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("vec%0d", i);
            load_mem(VECS[i]);
            run_walk(VECS[i].va, 52'h1000, VECS[i].acc, 1'b0);
            // R3 R8 R9 R10: fault code; R5 R6 R7: stop level
            chk({tag, " R3/R8/R9/R10 fault"}, {62'b0, r_flt}, {62'b0, VECS[i].flt});
            chk({tag, " R5/R6/R7 level"}, {61'b0, r_lvl}, {61'b0, VECS[i].lvl});
            if (VECS[i].flt == 2'd0)
                chk({tag, " R4/R5/R6 paddr"}, {12'b0, r_pa}, {12'b0, VECS[i].pa});
            chk({tag, " R2 read count"}, 64'(nrd), 64'(5 - int'(VECS[i].lvl)));
            for (int k = 0; k < 4 && k < nrd; k++) begin
                logic [51:0] ea;
                ea = 52'h1000 * 52'(k + 1)
                   + {40'b0, VECS[i].va[39 - 9*k +: 9], 3'b0};
                chk({tag, " R2 read address"}, {12'b0, rlog[k]}, {12'b0, ea});
            end
        end

        // R2: low bits of the root are forced to zero
        load_mem(VECS[0]);
        run_walk(VA0, 52'h1ABC, 3'b000, 1'b0);
        chk("R2 root low bits ignored", {12'b0, rlog[0]}, 64'h1008);
        chk("R2 root junk result", {12'b0, r_pa}, 64'hABCDE567);

        // R11: a request held high during a walk has no effect
        load_mem(VECS[0]);
        run_walk(VA0, 52'h1000, 3'b000, 1'b1);
        chk("R11 busy request ignored paddr", {12'b0, r_pa}, 64'hABCDE567);
        chk("R11 busy request ignored fault", {62'b0, r_flt}, 64'd0);
        chk("R11 busy request read count", 64'(nrd), 64'd4);
        nrd = 0;
        repeat (6) @(negedge clk);
        chk("R11 no walk started after busy request", 64'(nrd), 64'd0);
        chk("R11 still idle", {63'b0, req_ready}, 64'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule